// File: doc/BRIEF.md
# Backward Dependency Walker

This block extracts the address-generation slice for one load from a circular history of retired instructions. It is given the queue position of the load to explain and the position of the oldest valid entry. It reads the load first, marks the registers that the load's address depends on in a per-register source map, and then walks toward older entries at one entry per cycle. It keeps every older instruction whose destination is still wanted. A kept instruction hands its obligation on: its destination stops being wanted and its source registers become wanted. Each kept instruction goes into a fixed-depth slice buffer that fills from the highest slot downward, together with the result value the queue recorded for it, so that later passes can spot constants and strides.

A walk ends normally in one of three ways: nothing remains wanted, the oldest entry has been examined, or the walk meets the same load again under the same branch context. It stops early when the slice would grow past its capacity, or when the slice would need more distinct temporary registers than are allowed. A validation walk follows the same path but does not rewrite the stored operations. It compares each instruction it would keep against the stored one in the same slot, and at a normal end it compares the length as well. Any difference ends the walk with an inconsistency code. In validation mode the recorded values are refreshed, and the walker reports a one-cycle done pulse with a status code.

Top module: `dep_walker`

## Requirements
- R1: After reset `ready_o` is 1, `done_o` is 0, `status_o` is 0 and `slice_len_o` is 0. While idle without a start, status and length do not change.
- R2: In the cycle after a start is accepted, the queue entry at `start_ptr_i` is read and stored in slot SLICE_DEPTH-1 (slot 15 by default). Its valid sources alone become the wanted set, and the length becomes 1.
- R3: An older entry with a valid destination that is in the wanted set is stored in slot SLICE_DEPTH-1-len, and its result value is recorded with it. Its destination is then removed from the set, its valid sources are added, and the length rises by one. An operation is packed MSB first as {opcode, dst_valid, dst, src0_valid, src0, src1_valid, src1}, and slot i sits at bits [i*OP_W +: OP_W].
- R4: An entry whose destination is invalid or not wanted leaves the slice, the length and the wanted set unchanged.
- R5: Exactly one entry is examined per cycle. The read pointer starts at `start_ptr_i` and decreases by one each cycle, wrapping from 0 to HQ_DEPTH-1.
- R6: When a capture empties the wanted set, the walk ends with status 1.
- R7: When the entry at `tail_ptr_i` has been examined and the walk has not otherwise ended, the walk ends with status 2.
- R8: An entry other than the first that has `hq_ctx_match_i` set ends the walk with status 3, and that entry is not captured.
- R9: A wanted entry met when the length already equals SLICE_DEPTH ends the walk with status 4. The length never exceeds SLICE_DEPTH.
- R10: A capture that would raise the number of distinct destination registers among captured entries after the first above MAX_TMP (8) ends the walk with status 5, and that entry is not captured.
- R11: In validation mode the stored operations are kept. A wanted entry that differs from its stored slot, or that falls beyond the stored length, ends the walk with status 6. So does a normal end whose length differs from the length of the last successful generation walk. Values of matching captures are refreshed.
- R12: `done_o` is high for exactly one cycle, in the cycle after the last entry is examined, with `status_o` and `slice_len_o` valid. `ready_o` returns in the following cycle. A start while `ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only when ready) |
| validate_i | input | 1 | Walk is a validation pass |
| start_ptr_i | input | PTR_W | Queue position of the load |
| tail_ptr_i | input | PTR_W | Queue position of the oldest valid entry |
| ready_o | output | 1 | Walker is idle and accepts a start |
| hq_rd_ptr_o | output | PTR_W | Queue read address |
| hq_opc_i | input | OPC_W | Opcode of the entry read |
| hq_dst_vld_i | input | 1 | Entry writes a register |
| hq_dst_i | input | REG_W | Destination register id |
| hq_src0_vld_i | input | 1 | First source is used |
| hq_src0_i | input | REG_W | First source register id |
| hq_src1_vld_i | input | 1 | Second source is used |
| hq_src1_i | input | REG_W | Second source register id |
| hq_value_i | input | VAL_W | Result value recorded for the entry |
| hq_ctx_match_i | input | 1 | Entry is the same load in the same branch context |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Outcome code (R6 to R11) |
| slice_len_o | output | LEN_W | Number of captured operations |
| slice_ops_o | output | SLICE_DEPTH*OP_W | Packed slice operations |
| slice_vals_o | output | SLICE_DEPTH*VAL_W | Packed recorded values |

## Verification
The assertions cover every cycle. They check the single-cycle done pulse and the return to ready after it, the one-step decrement of the read pointer during a walk, a length that grows by at most one per cycle and never passes capacity, a non-zero status at done, a length of zero right after a start, and quiet outputs while idle. Only the bench scenarios can show which entries end up in which slot with which value, and which of the termination and abort codes a given history produces. Those scenarios are chains ending in an empty set, at the tail and on a repeated context. They also cover a self-updating register that fills the slice, a long register relay that wraps the queue and runs out of temporaries, and validation passes that pass, refresh values, or fail on an operation or a length.

// File: rtl/dep_walker_pkg.sv
package dep_walker_pkg;

   typedef enum logic [2:0] {
      WS_NONE     = 3'd0,
      WS_OK_EMPTY = 3'd1,
      WS_OK_TAIL  = 3'd2,
      WS_OK_LOOP  = 3'd3,
      WS_AB_LEN   = 3'd4,
      WS_AB_TMP   = 3'd5,
      WS_AB_DIFF  = 3'd6
   } walk_status_e;

   typedef enum logic [1:0] {
      FSM_IDLE,
      FSM_SEED,
      FSM_WALK,
      FSM_REPORT
   } walk_fsm_e;

   function automatic logic is_clean_end(input walk_status_e s);
      return (s == WS_OK_EMPTY) || (s == WS_OK_TAIL) || (s == WS_OK_LOOP);
   endfunction

endpackage

// File: rtl/dw_srcmap.sv
module dw_srcmap #(
   parameter int NUM_REGS = 32,
   parameter int REG_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_i,
   input  logic             cap_i,
   input  logic             dst_vld_i,
   input  logic [REG_W-1:0] dst_i,
   input  logic             s0_vld_i,
   input  logic [REG_W-1:0] s0_i,
   input  logic             s1_vld_i,
   input  logic [REG_W-1:0] s1_i,
   output logic             dst_hit_o,
   output logic             next_empty_o
);

   logic [NUM_REGS-1:0] map_q;
   logic [NUM_REGS-1:0] map_d;

   always_comb begin
      map_d = map_q;
      if (seed_i) begin
         map_d = '0;
      end else if (cap_i) begin
         map_d[dst_i] = 1'b0;
      end
      if (seed_i || cap_i) begin
         if (s0_vld_i) map_d[s0_i] = 1'b1;
         if (s1_vld_i) map_d[s1_i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q <= '0;
      else        map_q <= map_d;
   end

   assign dst_hit_o    = dst_vld_i & map_q[dst_i];
   assign next_empty_o = ~|map_d;

endmodule

// File: rtl/dw_tmp_track.sv
module dw_tmp_track #(
   parameter int NUM_REGS = 32,
   parameter int MAX_TMP  = 8,
   parameter bit DISTINCT = 1'b1,
   parameter int REG_W    = $clog2(NUM_REGS),
   parameter int CNT_W    = $clog2(NUM_REGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             cap_i,
   input  logic [REG_W-1:0] dst_i,
   output logic             over_o
);

   if (DISTINCT) begin : g_distinct
      logic [NUM_REGS-1:0] used_q;
      logic [NUM_REGS-1:0] cand;
      logic [CNT_W-1:0]    cnt;

      always_comb begin
         cand = used_q | (NUM_REGS'(1) << dst_i);
         cnt  = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            cnt = cnt + CNT_W'(cand[i]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      used_q <= '0;
         else if (clr_i)  used_q <= '0;
         else if (cap_i)  used_q <= cand;
      end

      assign over_o = (cnt > CNT_W'(MAX_TMP));
   end else begin : g_every
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (clr_i)  cnt_q <= '0;
         else if (cap_i)  cnt_q <= cnt_q + CNT_W'(1);
      end

      assign over_o = ((cnt_q + CNT_W'(1)) > CNT_W'(MAX_TMP));
   end

endmodule

// File: rtl/dw_slice_buf.sv
module dw_slice_buf #(
   parameter int DEPTH = 16,
   parameter int OP_W  = 26,
   parameter int VAL_W = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_i,
   input  logic                   wr_i,
   input  logic                   wr_op_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic [OP_W-1:0]        op_i,
   input  logic [VAL_W-1:0]       val_i,
   output logic [OP_W-1:0]        slot_op_o,
   output logic [DEPTH*OP_W-1:0]  ops_o,
   output logic [DEPTH*VAL_W-1:0] vals_o
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [OP_W-1:0]  op_q;
      logic [VAL_W-1:0] val_q;
      logic             sel;

      assign sel = wr_i && (idx_i == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            op_q  <= '0;
            val_q <= '0;
         end else if (clr_i) begin
            op_q  <= '0;
            val_q <= '0;
         end else if (sel) begin
            if (wr_op_i) op_q <= op_i;
            val_q <= val_i;
         end
      end

      assign ops_o[g*OP_W +: OP_W]    = op_q;
      assign vals_o[g*VAL_W +: VAL_W] = val_q;
   end

   assign slot_op_o = ops_o[idx_i*OP_W +: OP_W];

endmodule

// File: rtl/dep_walker.sv
module dep_walker
   import dep_walker_pkg::*;
#(
   parameter int HQ_DEPTH     = 128,
   parameter int NUM_REGS     = 32,
   parameter int SLICE_DEPTH  = 16,
   parameter int MAX_TMP      = 8,
   parameter int OPC_W        = 8,
   parameter int VAL_W        = 64,
   parameter bit DISTINCT_TMP = 1'b1,
   localparam int PTR_W       = $clog2(HQ_DEPTH),
   localparam int REG_W       = $clog2(NUM_REGS),
   localparam int LEN_W       = $clog2(SLICE_DEPTH + 1),
   localparam int IDX_W       = $clog2(SLICE_DEPTH),
   localparam int OP_W        = OPC_W + 3 * (REG_W + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic                         validate_i,
   input  logic [PTR_W-1:0]             start_ptr_i,
   input  logic [PTR_W-1:0]             tail_ptr_i,
   output logic                         ready_o,
   output logic [PTR_W-1:0]             hq_rd_ptr_o,
   input  logic [OPC_W-1:0]             hq_opc_i,
   input  logic                         hq_dst_vld_i,
   input  logic [REG_W-1:0]             hq_dst_i,
   input  logic                         hq_src0_vld_i,
   input  logic [REG_W-1:0]             hq_src0_i,
   input  logic                         hq_src1_vld_i,
   input  logic [REG_W-1:0]             hq_src1_i,
   input  logic [VAL_W-1:0]             hq_value_i,
   input  logic                         hq_ctx_match_i,
   output logic                         done_o,
   output logic [2:0]                   status_o,
   output logic [LEN_W-1:0]             slice_len_o,
   output logic [SLICE_DEPTH*OP_W-1:0]  slice_ops_o,
   output logic [SLICE_DEPTH*VAL_W-1:0] slice_vals_o
);

   // elaboration-time parameter checks
   if ((HQ_DEPTH < 2) || ((HQ_DEPTH & (HQ_DEPTH - 1)) != 0)) begin : g_bad_hq
      $error("dep_walker: HQ_DEPTH must be a power of two of at least 2");
   end
   if ((SLICE_DEPTH < 2) || ((SLICE_DEPTH & (SLICE_DEPTH - 1)) != 0)) begin : g_bad_slice
      $error("dep_walker: SLICE_DEPTH must be a power of two of at least 2");
   end
   if ((NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("dep_walker: NUM_REGS must be a power of two");
   end
   if ((MAX_TMP < 1) || (MAX_TMP >= NUM_REGS)) begin : g_bad_tmp
      $error("dep_walker: MAX_TMP must lie between 1 and NUM_REGS-1");
   end

   walk_fsm_e      state_q;
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] tail_q;
   logic           vmode_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] ref_len_q;
   walk_status_e   status_q;

   logic           in_seed;
   logic           in_walk;
   logic           accept;
   logic           ctx_stop;
   logic           hit;
   logic           ab_len;
   logic           ab_tmp;
   logic           mism;
   logic           cap;
   logic           dst_hit;
   logic           next_empty;
   logic           tmp_over;
   logic [LEN_W-1:0] len_nxt;
   logic [IDX_W-1:0] wr_idx;
   logic [OP_W-1:0]  op_in;
   logic [OP_W-1:0]  slot_op;
   logic           fin;
   walk_status_e   fin_code;
   walk_status_e   ok_code;

   assign in_seed = (state_q == FSM_SEED);
   assign in_walk = (state_q == FSM_WALK);
   assign accept  = (state_q == FSM_IDLE) && start_i;

   assign op_in = {hq_opc_i, hq_dst_vld_i, hq_dst_i,
                   hq_src0_vld_i, hq_src0_i, hq_src1_vld_i, hq_src1_i};

   // per-entry decision
   assign ctx_stop = in_walk && hq_ctx_match_i;
   assign hit      = in_seed || (in_walk && !ctx_stop && dst_hit);
   assign ab_len   = hit && (len_q == LEN_W'(SLICE_DEPTH));
   assign ab_tmp   = hit && in_walk && !ab_len && tmp_over;
   assign wr_idx   = IDX_W'(SLICE_DEPTH - 1) - IDX_W'(len_q);
   assign mism     = hit && vmode_q && !ab_len && !ab_tmp &&
                     ((len_q >= ref_len_q) || (slot_op != op_in));
   assign cap      = hit && !ab_len && !ab_tmp && !mism;
   assign len_nxt  = len_q + LEN_W'(cap);

   dw_srcmap #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W)
   ) u_srcmap (
      .clk          (clk),
      .rst_n        (rst_n),
      .seed_i       (in_seed),
      .cap_i        (cap && in_walk),
      .dst_vld_i    (hq_dst_vld_i),
      .dst_i        (hq_dst_i),
      .s0_vld_i     (hq_src0_vld_i),
      .s0_i         (hq_src0_i),
      .s1_vld_i     (hq_src1_vld_i),
      .s1_i         (hq_src1_i),
      .dst_hit_o    (dst_hit),
      .next_empty_o (next_empty)
   );

   dw_tmp_track #(
      .NUM_REGS (NUM_REGS),
      .MAX_TMP  (MAX_TMP),
      .DISTINCT (DISTINCT_TMP),
      .REG_W    (REG_W)
   ) u_tmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .cap_i  (cap && in_walk),
      .dst_i  (hq_dst_i),
      .over_o (tmp_over)
   );

   dw_slice_buf #(
      .DEPTH (SLICE_DEPTH),
      .OP_W  (OP_W),
      .VAL_W (VAL_W),
      .IDX_W (IDX_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (accept && !validate_i),
      .wr_i      (cap),
      .wr_op_i   (!vmode_q),
      .idx_i     (wr_idx),
      .op_i      (op_in),
      .val_i     (hq_value_i),
      .slot_op_o (slot_op),
      .ops_o     (slice_ops_o),
      .vals_o    (slice_vals_o)
   );

   // termination priority: context repeat, aborts, empty set, tail
   always_comb begin
      ok_code  = WS_NONE;
      fin_code = WS_NONE;
      if (in_seed || in_walk) begin
         if (ctx_stop)                   ok_code  = WS_OK_LOOP;
         else if (ab_len)                fin_code = WS_AB_LEN;
         else if (ab_tmp)                fin_code = WS_AB_TMP;
         else if (mism)                  fin_code = WS_AB_DIFF;
         else if (cap && next_empty)     ok_code  = WS_OK_EMPTY;
         else if (ptr_q == tail_q)       ok_code  = WS_OK_TAIL;
         if (ok_code != WS_NONE) begin
            fin_code = (vmode_q && (len_nxt != ref_len_q)) ? WS_AB_DIFF : ok_code;
         end
      end
      fin = (fin_code != WS_NONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= FSM_IDLE;
         ptr_q     <= '0;
         tail_q    <= '0;
         vmode_q   <= 1'b0;
         len_q     <= '0;
         ref_len_q <= '0;
         status_q  <= WS_NONE;
      end else begin
         unique case (state_q)
            FSM_IDLE: begin
               if (start_i) begin
                  ptr_q    <= start_ptr_i;
                  tail_q   <= tail_ptr_i;
                  vmode_q  <= validate_i;
                  len_q    <= '0;
                  status_q <= WS_NONE;
                  state_q  <= FSM_SEED;
               end
            end
            FSM_SEED, FSM_WALK: begin
               len_q <= len_nxt;
               if (fin) begin
                  status_q <= fin_code;
                  state_q  <= FSM_REPORT;
                  if (!vmode_q && is_clean_end(fin_code)) begin
                     ref_len_q <= len_nxt;
                  end
               end else begin
                  ptr_q   <= ptr_q - PTR_W'(1);
                  state_q <= FSM_WALK;
               end
            end
            FSM_REPORT: begin
               state_q <= FSM_IDLE;
            end
            default: state_q <= FSM_IDLE;
         endcase
      end
   end

   assign ready_o     = (state_q == FSM_IDLE);
   assign done_o      = (state_q == FSM_REPORT);
   assign hq_rd_ptr_o = ptr_q;
   assign status_o    = status_q;
   assign slice_len_o = len_q;

endmodule

// File: rtl/dw_walker_chk.sv
module dw_walker_chk #(
   parameter int PTR_W       = 7,
   parameter int LEN_W       = 5,
   parameter int SLICE_DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             ready,
   input logic             done,
   input logic [2:0]       status,
   input logic [LEN_W-1:0] len,
   input logic [PTR_W-1:0] rd_ptr
);

   // R1: quiet outputs while idle and not started
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && !$past(start)) |-> ($stable(status) && $stable(len)));

   // R2: a fresh walk begins with an empty slice
   p_seed_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ready) && $past(start) && !ready) |-> (len == '0));

   // R3: length grows by at most one per cycle
   p_len_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |->
         ((len == $past(len)) || (len == LEN_W'($past(len) + 1'b1))));

   // R5: one entry per cycle, pointer stepping downward
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !done && $past(!ready && !done)) |->
         (rd_ptr == PTR_W'($past(rd_ptr) - 1'b1)));

   // R6: a finished walk always carries an outcome
   p_done_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 3'd0));

   // R9: slice length bounded by capacity
   p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      len <= LEN_W'(SLICE_DEPTH));

   // R12: single-cycle done, then ready
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

endmodule

bind dep_walker dw_walker_chk #(
   .PTR_W       (PTR_W),
   .LEN_W       (LEN_W),
   .SLICE_DEPTH (SLICE_DEPTH)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start_i),
   .ready  (ready_o),
   .done   (done_o),
   .status (status_o),
   .len    (slice_len_o),
   .rd_ptr (hq_rd_ptr_o)
);

// File: tb/dep_walker_tb_top.sv
module dep_walker_tb_top;

   localparam int HQ   = 128;
   localparam int SD   = 16;
   localparam int OPW  = 26;
   localparam int VW   = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic vmode = 1'b0;
   logic [6:0] s_ptr = '0;
   logic [6:0] t_ptr = '0;

   logic ready, done;
   logic [6:0] rd_ptr;
   logic [2:0] status;
   logic [4:0] slen;
   logic [SD*OPW-1:0] sops;
   logic [SD*VW-1:0]  svals;

   logic [7:0]  q_opc [HQ];
   logic        q_dv  [HQ];
   logic [4:0]  q_dst [HQ];
   logic        q_s0v [HQ];
   logic [4:0]  q_s0  [HQ];
   logic        q_s1v [HQ];
   logic [4:0]  q_s1  [HQ];
   logic [63:0] q_val [HQ];
   logic        q_ctx [HQ];

   logic [OPW-1:0] m_ops  [SD];
   logic [VW-1:0]  m_vals [SD];
   int             m_ref_len = 0;
   int             m_len_tr [256];

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dep_walker dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .validate_i     (vmode),
      .start_ptr_i    (s_ptr),
      .tail_ptr_i     (t_ptr),
      .ready_o        (ready),
      .hq_rd_ptr_o    (rd_ptr),
      .hq_opc_i       (q_opc[rd_ptr]),
      .hq_dst_vld_i   (q_dv[rd_ptr]),
      .hq_dst_i       (q_dst[rd_ptr]),
      .hq_src0_vld_i  (q_s0v[rd_ptr]),
      .hq_src0_i      (q_s0[rd_ptr]),
      .hq_src1_vld_i  (q_s1v[rd_ptr]),
      .hq_src1_i      (q_s1[rd_ptr]),
      .hq_value_i     (q_val[rd_ptr]),
      .hq_ctx_match_i (q_ctx[rd_ptr]),
      .done_o         (done),
      .status_o       (status),
      .slice_len_o    (slen),
      .slice_ops_o    (sops),
      .slice_vals_o   (svals)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [OPW-1:0] mk_op(input int p);
      return {q_opc[p], q_dv[p], q_dst[p], q_s0v[p], q_s0[p], q_s1v[p], q_s1[p]};
   endfunction

   function automatic string st_req(input int s);
      case (s)
         1: return "R6";
         2: return "R7";
         3: return "R8";
         4: return "R9";
         5: return "R10";
         6: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic put(input int i, input int opc, input bit dv, input int dst,
                      input bit s0v, input int s0, input bit s1v, input int s1,
                      input longint val, input bit ctx);
      q_opc[i] = 8'(opc); q_dv[i] = dv; q_dst[i] = 5'(dst);
      q_s0v[i] = s0v; q_s0[i] = 5'(s0); q_s1v[i] = s1v; q_s1[i] = 5'(s1);
      q_val[i] = 64'(val); q_ctx[i] = ctx;
   endtask

   task automatic clear_q();
      for (int i = 0; i < HQ; i++) put(i, 8'hEE, 1'b1, 31, 1'b0, 0, 1'b0, 0, 64'(i) + 64'h500, 1'b0);
   endtask

   // behavioural reference of one walk
   task automatic predict(input int sp, input int tp, input bit vm,
                          output int n, output int st, output int ln);
      logic [31:0] bm;
      logic [31:0] used;
      int p;
      bit stop;
      bm = '0; used = '0; p = sp; ln = 0; st = 0; n = 0; stop = 0;
      if (!vm) for (int i = 0; i < SD; i++) begin m_ops[i] = '0; m_vals[i] = '0; end
      for (int k = 0; k < 250 && !stop; k++) begin
         int okc;
         bit hit;
         okc = 0;
         hit = 0;
         m_len_tr[k] = ln;
         n = k + 1;
         if (k > 0 && q_ctx[p]) okc = 3;
         else begin
            hit = (k == 0) || (q_dv[p] && bm[q_dst[p]]);
            if (hit) begin
               if (ln == SD) begin st = 4; stop = 1; end
               else begin
                  if (k > 0 && $countones(used | (32'd1 << q_dst[p])) > 8) begin st = 5; stop = 1; end
                  if (!stop && vm && (ln >= m_ref_len || m_ops[SD-1-ln] != mk_op(p))) begin st = 6; stop = 1; end
               end
               if (!stop) begin
                  if (!vm) m_ops[SD-1-ln] = mk_op(p);
                  m_vals[SD-1-ln] = q_val[p];
                  if (k == 0) bm = '0; else bm[q_dst[p]] = 1'b0;
                  if (q_s0v[p]) bm[q_s0[p]] = 1'b1;
                  if (q_s1v[p]) bm[q_s1[p]] = 1'b1;
                  if (k > 0) used = used | (32'd1 << q_dst[p]);
                  ln++;
                  if (bm == '0) okc = 1;
               end
            end
            if (!stop && okc == 0 && p == tp) okc = 2;
         end
         if (okc != 0) begin
            stop = 1;
            if (vm && ln != m_ref_len) st = 6;
            else begin
               st = okc;
               if (!vm) m_ref_len = ln;
            end
         end
         p = (p - 1) & (HQ - 1);
      end
   endtask

   task automatic run_walk(input int sp, input int tp, input bit vm, input bit poke,
                           input string name);
      int n, st, ln;
      @(negedge clk);
      start = 1'b1; s_ptr = 7'(sp); t_ptr = 7'(tp); vmode = vm;
      predict(sp, tp, vm, n, st, ln);
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < n; c++) begin
         chk("R12", {name, " busy ready"}, 64'(ready), 64'd0);
         chk("R12", {name, " busy done"}, 64'(done), 64'd0);
         chk("R5",  {name, " read pointer"}, 64'(rd_ptr), 64'((sp - c) & (HQ - 1)));
         chk("R4",  {name, " running length"}, 64'(slen), 64'(m_len_tr[c]));
         if (poke && c == 1) begin
            start = 1'b1; s_ptr = 7'((sp + 5) & (HQ - 1)); vmode = ~vm;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R12", {name, " done pulse"}, 64'(done), 64'd1);
      chk(st_req(st), {name, " status"}, 64'(status), 64'(st));
      chk("R3", {name, " final length"}, 64'(slen), 64'(ln));
      for (int s = 0; s < SD; s++) begin
         chk((s == SD - 1) ? "R2" : "R3", {name, " slot op"},
             64'(sops[s*OPW +: OPW]), 64'(m_ops[s]));
         chk((s == SD - 1) ? "R2" : "R3", {name, " slot value"},
             svals[s*VW +: VW], m_vals[s]);
      end
      @(negedge clk);
      chk("R12", {name, " ready after done"}, 64'(ready), 64'd1);
      chk("R12", {name, " done dropped"}, 64'(done), 64'd0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R12 watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clear_q();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset ready", 64'(ready), 64'd1);
      chk("R1", "reset done", 64'(done), 64'd0);
      chk("R1", "reset status", 64'(status), 64'd0);
      chk("R1", "reset length", 64'(slen), 64'd0);
      repeat (2) @(negedge clk);
      chk("R1", "idle status held", 64'(status), 64'd0);

      // A: chain to an empty set, with a start poked while busy
      put(40, 8'h10, 1, 3, 1, 1, 0, 0, 64'h1000, 0);
      put(39, 8'h21, 1, 5, 1, 6, 0, 0, 64'h11, 0);
      put(38, 8'h30, 1, 1, 1, 2, 1, 4, 64'd100, 0);
      put(37, 8'h40, 0, 0, 1, 1, 0, 0, 64'h0, 0);
      put(36, 8'h50, 1, 2, 0, 0, 0, 0, 64'd7, 0);
      put(35, 8'h50, 1, 4, 0, 0, 0, 0, 64'd9, 0);
      run_walk(40, 0, 1'b0, 1'b1, "gen-empty");

      // B: validation of an unchanged history
      run_walk(40, 0, 1'b1, 1'b0, "val-same");
      // C: value change only, slice values refreshed
      q_val[38] = 64'd108;
      run_walk(40, 0, 1'b1, 1'b0, "val-newval");
      // D: operation change
      q_s0v[36] = 1'b1; q_s0[36] = 5'd6;
      run_walk(40, 0, 1'b1, 1'b0, "val-opdiff");
      q_s0v[36] = 1'b0; q_s0[36] = 5'd0;
      // E: shorter chain reaching the tail
      q_dst[35] = 5'd5;
      run_walk(40, 0, 1'b1, 1'b0, "val-lendiff");

      // F: repeated context
      clear_q();
      put(80, 8'h10, 1, 3, 1, 7, 0, 0, 64'h2000, 0);
      put(79, 8'h31, 1, 7, 1, 7, 0, 0, 64'h40, 0);
      put(78, 8'h10, 1, 3, 1, 7, 0, 0, 64'h1FF8, 1);
      run_walk(80, 0, 1'b0, 1'b0, "gen-loop");

      // G: tail reached
      clear_q();
      put(10, 8'h10, 1, 3, 1, 9, 0, 0, 64'h3000, 0);
      run_walk(10, 8, 1'b0, 1'b0, "gen-tail");

      // H: load without sources
      put(50, 8'h11, 1, 3, 0, 0, 0, 0, 64'h4000, 0);
      run_walk(50, 0, 1'b0, 1'b0, "gen-nosrc");

      // I: self-updating register fills the slice
      clear_q();
      put(100, 8'h10, 1, 3, 1, 1, 0, 0, 64'h5000, 0);
      for (int i = 80; i < 100; i++) put(i, 8'h32, 1, 1, 1, 1, 0, 0, 64'(i), 0);
      run_walk(100, 60, 1'b0, 1'b0, "gen-lenlimit");

      // J: register relay across the wrap point exhausts temporaries
      clear_q();
      put(3, 8'h10, 1, 3, 1, 10, 0, 0, 64'h6000, 0);
      for (int j = 0; j < 9; j++) begin
         put((2 - j) & (HQ - 1), 8'h51, 1, 10 + j, 1, 11 + j, 0, 0, 64'(j + 1), 0);
      end
      run_walk(3, 100, 1'b0, 1'b0, "gen-tmplimit");

      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule